// File: doc/BRIEF.md
# Preempted-Priority Save Stack

This block keeps the priority levels that an interrupt controller sets aside each time a more urgent request preempts the running handler. Every acknowledge of an interrupt pushes the current priority. Every end-of-interrupt pops the stack, and the value it returns becomes the running priority again. Handler code therefore never has to save or restore the priority itself. The stack is reached only through its push and pop strobes and has no address space of its own.

Neither overflow nor underflow is an error. There are sixteen priority levels, but a handler at the top level is never preempted, so at most fifteen levels can ever be saved. The stack still holds only fourteen. When it is full, a push discards the oldest entry, and a pop from an empty stack yields level 0. In any legal nesting the entry that gets discarded is always the level-0 entry, and the empty pop recreates it. The stack therefore behaves correctly without storage for level 0.

Top module: `prio_lifo`

## Requirements
- R1: A synchronous reset (rst high at a rising clk edge) leaves level_o at 0, empty_o at 1, full_o at 0 and pop_prio_o at 0.
- R2: A push without a pop on a non-full stack stores the 4-bit push_prio_i. Any value from 0 to 15 can be stored. From the next cycle the value is the top entry, and level_o rises by one.
- R3: pop_prio_o shows the top entry combinationally in the cycle that pop_i is high. A pop without a push on a non-empty stack removes that entry and lowers level_o by one. Successive pops return the values in the reverse order of their pushes.
- R4: A push without a pop on a full stack (level_o = 14) keeps level_o at 14 and discards the oldest entry. After the values 1 to 15 are pushed in that order, fourteen pops return 15 down to 2.
- R5: A pop on an empty stack returns 0 on pop_prio_o and leaves level_o at 0. It has no effect on later pushes and pops.
- R6: A push and a pop in the same cycle on a non-empty stack return the prior top on pop_prio_o. The pushed value replaces the top entry and level_o is unchanged, even when the stack is full. On an empty stack the pop returns 0 and the push is stored, so level_o becomes 1.
- R7: full_o is 1 exactly when level_o equals 14, and empty_o is 1 exactly when level_o equals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe (interrupt acknowledge) |
| push_prio_i | input | 4 | Priority value to save |
| pop_i | input | 1 | Pop strobe (end of interrupt) |
| pop_prio_o | output | 4 | Top entry, or 0 when empty; valid while pop_i is high |
| level_o | output | 4 | Number of stored entries, 0 to 14 |
| full_o | output | 1 | Stack holds 14 entries |
| empty_o | output | 1 | Stack holds no entries |

## Verification
A push and a pop can fall in the same cycle. This happens when one handler ends in the same cycle that the next request is acknowledged. The bench provokes it on a stack with two entries, on a full stack and on an empty stack. It judges the result from the value returned in that cycle, from level_o in the following cycle, and from the order of values that later pops drain out of the stack.

// File: rtl/prio_lifo_pkg.sv
package prio_lifo_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

  // Occupancy after one cycle, saturating at both ends.
  function automatic int lvl_next(input int lvl, input bit psh, input bit pp,
                                  input int depth);
    if (psh && pp)  return (lvl == 0) ? 1 : lvl;
    if (psh)        return (lvl >= depth) ? depth : lvl + 1;
    if (pp)         return (lvl == 0) ? 0 : lvl - 1;
    return lvl;
  endfunction

endpackage

// File: rtl/prio_lifo_ctrl.sv
module prio_lifo_ctrl
  import prio_lifo_pkg::*;
#(
  parameter int DEPTH = 14,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  output stk_op_e          op_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o,
  output logic             under_o
);

  logic [LVL_W-1:0] level_q;

  always_comb begin
    empty_o = (level_q == '0);
    full_o  = (level_q == LVL_W'(DEPTH));
    if (push_i && pop_i && !empty_o) op_o = OP_SWAP;
    else if (push_i)                 op_o = OP_PUSH;
    else if (pop_i && !empty_o)      op_o = OP_POP;
    else                             op_o = OP_HOLD;
    drop_o  = push_i && !pop_i && full_o;
    under_o = pop_i && empty_o;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= LVL_W'(lvl_next(int'(level_q), push_i, pop_i, DEPTH));
  end

  assign level_o = level_q;

endmodule

// File: rtl/prio_lifo_slot.sv
module prio_lifo_slot
  import prio_lifo_pkg::*;
#(
  parameter int  PRIO_W = 4,
  parameter bit  IS_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op_i,
  input  logic [PRIO_W-1:0] above_i,
  input  logic [PRIO_W-1:0] below_i,
  output logic [PRIO_W-1:0] val_o
);

  logic [PRIO_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: val_q <= above_i;
        OP_POP:  val_q <= below_i;
        OP_SWAP: if (IS_TOP) val_q <= above_i;
        default: val_q <= val_q;
      endcase
    end
  end

  assign val_o = val_q;

endmodule

// File: rtl/prio_lifo.sv
module prio_lifo
  import prio_lifo_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 14,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [PRIO_W-1:0] pop_prio_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o
);

  stk_op_e           op_w;
  logic              drop_oldest_w;
  logic              pop_underflow_w;
  logic [PRIO_W-1:0] stk_w [DEPTH];

  prio_lifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .op_o    (op_w),
    .level_o (level_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .drop_o  (drop_oldest_w),
    .under_o (pop_underflow_w)
  );

  // Entry 0 is the top; entry DEPTH-1 is the oldest and falls off on overflow.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PRIO_W-1:0] above_w, below_w;
    if (g == 0) begin : g_top
      assign above_w = push_prio_i;
    end else begin : g_mid
      assign above_w = stk_w[g-1];
    end
    if (g == DEPTH - 1) begin : g_last
      assign below_w = '0;
    end else begin : g_inner
      assign below_w = stk_w[g+1];
    end
    prio_lifo_slot #(.PRIO_W(PRIO_W), .IS_TOP(g == 0)) slot_i (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op_w),
      .above_i (above_w),
      .below_i (below_w),
      .val_o   (stk_w[g])
    );
  end

  assign pop_prio_o = empty_o ? '0 : stk_w[0];

endmodule

// File: rtl/prio_lifo_chk.sv
module prio_lifo_chk #(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 14,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_i,
  input logic [PRIO_W-1:0] push_prio_i,
  input logic              pop_i,
  input logic [PRIO_W-1:0] pop_prio_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              drop_oldest,
  input logic              pop_underflow
);

  AST_PUSH_TOPS: assert property (@(posedge clk) disable iff (rst)
    push_i |=> (pop_prio_o == $past(push_prio_i))); // R2
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && !full_o) |=> (level_o == $past(level_o) + 1'b1)); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !empty_o) |=> (level_o == $past(level_o) - 1'b1)); // R3
  AST_OVERFLOW_SAT: assert property (@(posedge clk) disable iff (rst)
    drop_oldest |=> full_o); // R4
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    pop_underflow |-> (pop_prio_o == '0)); // R5
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pop_underflow && !push_i) |=> empty_o); // R5
  AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !empty_o) |=> $stable(level_o)); // R6
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    level_o <= LVL_W'(DEPTH)); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o)); // R7

endmodule

bind prio_lifo prio_lifo_chk #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .push_i        (push_i),
  .push_prio_i   (push_prio_i),
  .pop_i         (pop_i),
  .pop_prio_o    (pop_prio_o),
  .level_o       (level_o),
  .full_o        (full_o),
  .empty_o       (empty_o),
  .drop_oldest   (drop_oldest_w),
  .pop_underflow (pop_underflow_w)
);

// File: tb/prio_lifo_tb.sv
module prio_lifo_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_i = 1'b0;
  logic [3:0] push_prio_i = '0;
  logic       pop_i = 1'b0;
  logic [3:0] pop_prio_o;
  logic [3:0] level_o;
  logic       full_o, empty_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_lifo dut_i (
    .clk (clk), .rst (rst), .push_i (push_i), .push_prio_i (push_prio_i),
    .pop_i (pop_i), .pop_prio_o (pop_prio_o), .level_o (level_o),
    .full_o (full_o), .empty_o (empty_o)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end 1 ns after a rising edge.
  task automatic tick();
    @(posedge clk); #1;
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic push(input int v);
    push_i = 1'b1; push_prio_i = 4'(v); tick();
  endtask

  task automatic pop_exp(input int exp, input string req);
    pop_i = 1'b1; #2;
    check(int'(pop_prio_o), exp, req);
    tick();
  endtask

  task automatic both_exp(input int v, input int exp, input string req);
    push_i = 1'b1; pop_i = 1'b1; push_prio_i = 4'(v); #2;
    check(int'(pop_prio_o), exp, req);
    tick();
  endtask

  task automatic t_reset();
    push(5); push(6);
    do_reset();
    check(int'(level_o), 0, "R1 level");
    check(int'(empty_o), 1, "R1 empty");
    check(int'(full_o), 0, "R1 full");
    pop_exp(0, "R1 pop after reset");
  endtask

  task automatic t_order();
    do_reset();
    push(4); push(0); push(15); push(9);
    check(int'(level_o), 4, "R2 level");
    pop_exp(9, "R3 order");
    check(int'(level_o), 3, "R3 level");
    pop_exp(15, "R3 order");
    pop_exp(0, "R2 value 0 kept");
    check(int'(level_o), 1, "R2 zero counted");
    pop_exp(4, "R3 order");
    check(int'(empty_o), 1, "R7 empty");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 15; i++) begin
      push(i);
      if (i == 13) check(int'(full_o), 0, "R7 not full at 13");
    end
    check(int'(level_o), 14, "R4 level saturates");
    check(int'(full_o), 1, "R7 full");
    for (int i = 15; i >= 2; i--) pop_exp(i, "R4 drain");
    check(int'(empty_o), 1, "R4 empty after drain");
    pop_exp(0, "R4 regenerated zero");
  endtask

  task automatic t_underflow();
    do_reset();
    for (int i = 0; i < 3; i++) pop_exp(0, "R5 empty pop");
    check(int'(level_o), 0, "R5 level");
    push(11);
    check(int'(level_o), 1, "R5 push after underflow");
    pop_exp(11, "R5 value after underflow");
  endtask

  task automatic t_simul();
    do_reset();
    push(3); push(7);
    both_exp(12, 7, "R6 prior top");
    check(int'(level_o), 2, "R6 level kept");
    pop_exp(12, "R6 replaced top");
    pop_exp(3, "R6 below untouched");
    both_exp(5, 0, "R6 empty returns 0");
    check(int'(level_o), 1, "R6 empty stores push");
    pop_exp(5, "R6 empty stored value");
    for (int i = 1; i <= 14; i++) push(i);
    both_exp(2, 14, "R6 full prior top");
    check(int'(level_o), 14, "R6 full level kept");
    pop_exp(2, "R6 full replaced");
    pop_exp(13, "R6 full below");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    t_reset();
    t_order();
    t_overflow();
    t_underflow();
    t_simul();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule